// File: doc/BRIEF.md
# Temperature Result Register with Window Alarm

This block sits on the device side of a digital thermometer, between the conversion engine and the serial bus logic. Each time a conversion finishes, the engine presents a signed 9-bit result in half-degree steps and pulses a valid strobe. On that clock edge the block widens the result into a 16-bit two's-complement register and re-evaluates a window alarm against two signed 8-bit limits.

The alarm compares only the whole-degree part of the result, which is register bits 8 down to 1, read as a signed byte. The alarm is raised when this value lies strictly above the high limit or strictly below the low limit. The flag changes only when a conversion completes. Moving a limit between conversions leaves the flag as it is until the next strobe. After reset the register holds +85.0 degrees and the flag is clear.

Top module: `thermo_alarm_reg`

## Requirements
- R1: While `rst_n` is low, and after it is released with no strobe yet, `temp_reg` reads 16'h00AA (+85.0) and `alarm` reads 0.
- R2: On a clock edge with `conv_valid` high, `temp_reg` takes `conv_result` in bits 8..0. Bits 15..9 become copies of bit 8. The new value is visible after that edge. Examples: 9'h032 gives 16'h0032, 9'h001 gives 16'h0001, 9'h1FF gives 16'hFFFF, 9'h1CE gives 16'hFFCE, and 9'h192 gives 16'hFF92.
- R3: On a clock edge with `conv_valid` low, `temp_reg` and `alarm` keep their values.
- R4: A strobe whose whole-degree value, taken as signed result bits 8..1, is greater than the signed `lim_high` sets `alarm` after that edge.
- R5: A strobe whose whole-degree value is less than the signed `lim_low` sets `alarm` after that edge.
- R6: A strobe whose whole-degree value lies between `lim_low` and `lim_high`, with both bounds included, clears `alarm` after that edge. Equality with either limit does not raise the alarm.
- R7: Changes to `lim_high` or `lim_low` while `conv_valid` is low do not change `alarm`.
- R8: Result bit 0 (the half degree) has no effect on the alarm. For example, +25.5 against a high limit of 25 gives no alarm. The whole-degree value rounds towards minus infinity, so -25.5 counts as -26.
- R9: Both limits and the whole-degree value are compared as signed numbers. A negative limit byte, such as 8'hE7 for -25, lies below every positive value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_valid | input | 1 | Conversion-complete strobe, one cycle per result |
| conv_result | input | 9 | Signed result, LSB weighs 0.5 degree |
| lim_high | input | 8 | Signed upper alarm limit, whole degrees |
| lim_low | input | 8 | Signed lower alarm limit, whole degrees |
| temp_reg | output | 16 | Sign-extended temperature register |
| alarm | output | 1 | Alarm flag, updated on each strobe |

## Verification
The assertions assume that `conv_result`, `lim_high` and `lim_low` are known whenever `conv_valid` is sampled high. They do not assume that `lim_low` is at or below `lim_high`, so either limit alone can raise the alarm. The bench drives every input at the falling edge and holds it across the rising edge. Its random phase allows inverted windows, and it often leaves the strobe low while it moves the limits. Directed phases hit each limit exactly, one step either side of it, and both values of the half-degree bit.

// File: rtl/thermo_alarm_pkg.sv
package thermo_alarm_pkg;

   typedef struct packed {
      logic above;
      logic below;
   } lim_cmp_t;

   function automatic logic window_violation(input lim_cmp_t c);
      return c.above | c.below;
   endfunction

endpackage

// File: rtl/tar_sign_ext.sv
module tar_sign_ext #(
   parameter int IN_W  = 9,
   parameter int OUT_W = 16
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   localparam int PAD_W = OUT_W - IN_W;

   generate
      if (PAD_W < 0) begin : g_bad
         $error("tar_sign_ext: OUT_W must not be below IN_W");
      end else if (PAD_W == 0) begin : g_same
         assign dout = din;
      end else begin : g_pad
         assign dout = {{PAD_W{din[IN_W-1]}}, din};
      end
   endgenerate
endmodule

// File: rtl/tar_window_cmp.sv
module tar_window_cmp
   import thermo_alarm_pkg::*;
#(
   parameter int LIM_W = 8
) (
   input  logic [LIM_W-1:0] whole_deg,
   input  logic [LIM_W-1:0] hi_lim,
   input  logic [LIM_W-1:0] lo_lim,
   output lim_cmp_t         cmp
);
   logic signed [LIM_W-1:0] v_s, hi_s, lo_s;

   assign v_s  = $signed(whole_deg);
   assign hi_s = $signed(hi_lim);
   assign lo_s = $signed(lo_lim);

   always_comb begin
      cmp.above = (v_s > hi_s);
      cmp.below = (v_s < lo_s);
   end
endmodule

// File: rtl/tar_state.sv
module tar_state #(
   parameter int          REG_W     = 16,
   parameter logic [15:0] RESET_VAL = 16'h00AA
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [REG_W-1:0] next_word,
   input  logic             next_flag,
   output logic [REG_W-1:0] word_q,
   output logic             flag_q
);
   localparam logic [REG_W-1:0] INIT_WORD = REG_W'(RESET_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= INIT_WORD;
         flag_q <= 1'b0;
      end else if (load) begin
         word_q <= next_word;
         flag_q <= next_flag;
      end
   end
endmodule

// File: rtl/thermo_alarm_reg.sv
module thermo_alarm_reg
   import thermo_alarm_pkg::*;
#(
   parameter int          RES_W     = 9,
   parameter int          REG_W     = 16,
   parameter int          LIM_W     = 8,
   parameter logic [15:0] RESET_VAL = 16'h00AA
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_valid,
   input  logic [RES_W-1:0] conv_result,
   input  logic [LIM_W-1:0] lim_high,
   input  logic [LIM_W-1:0] lim_low,
   output logic [REG_W-1:0] temp_reg,
   output logic             alarm
);
   localparam int CMP_LSB = 1;
   localparam int CMP_MSB = LIM_W;

   generate
      if (RES_W < 2) begin : g_chk_res
         $error("thermo_alarm_reg: RES_W must be at least 2");
      end
      if (REG_W < RES_W || REG_W > 16) begin : g_chk_reg
         $error("thermo_alarm_reg: REG_W must lie in RES_W..16");
      end
      if (CMP_MSB > RES_W - 1) begin : g_chk_lim
         $error("thermo_alarm_reg: LIM_W must be below RES_W");
      end
   endgenerate

   logic [REG_W-1:0] ext_word;
   lim_cmp_t         cmp;
   logic             next_flag;

   tar_sign_ext #(.IN_W(RES_W), .OUT_W(REG_W)) u_ext (
      .din  (conv_result),
      .dout (ext_word)
   );

   tar_window_cmp #(.LIM_W(LIM_W)) u_cmp (
      .whole_deg (ext_word[CMP_MSB:CMP_LSB]),
      .hi_lim    (lim_high),
      .lo_lim    (lim_low),
      .cmp       (cmp)
   );

   assign next_flag = window_violation(cmp);

   tar_state #(.REG_W(REG_W), .RESET_VAL(RESET_VAL)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (conv_valid),
      .next_word (ext_word),
      .next_flag (next_flag),
      .word_q    (temp_reg),
      .flag_q    (alarm)
   );
endmodule

// File: rtl/thermo_alarm_reg_chk.sv
module thermo_alarm_reg_chk #(
   parameter int RES_W = 9,
   parameter int REG_W = 16,
   parameter int LIM_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             conv_valid,
   input logic [RES_W-1:0] conv_result,
   input logic [LIM_W-1:0] lim_high,
   input logic [LIM_W-1:0] lim_low,
   input logic [REG_W-1:0] temp_reg,
   input logic             alarm
);
   logic signed [LIM_W-1:0] whole_in;
   logic                    over_in, under_in;

   assign whole_in = $signed(conv_result[LIM_W:1]);
   assign over_in  = whole_in > $signed(lim_high);
   assign under_in = whole_in < $signed(lim_low);

   // R2: the low bits follow the strobed result
   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_valid |=> temp_reg[RES_W-1:0] == $past(conv_result));

   // R2: the upper bits are copies of the sign bit
   assert_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_valid |=> ($countones(temp_reg[REG_W-1:RES_W-1]) == 0) ||
                     ($countones(temp_reg[REG_W-1:RES_W-1]) == REG_W-RES_W+1));

   // R3 and R7: without a strobe, both outputs stay as they were
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_valid |=> $stable(temp_reg) && $stable(alarm));

   assert_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_valid && over_in |=> alarm);

   assert_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      conv_valid && under_in |=> alarm);

   assert_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_valid && !over_in && !under_in |=> !alarm);
endmodule

bind thermo_alarm_reg thermo_alarm_reg_chk #(
   .RES_W(RES_W), .REG_W(REG_W), .LIM_W(LIM_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_result(conv_result),
   .lim_high(lim_high), .lim_low(lim_low), .temp_reg(temp_reg), .alarm(alarm)
);

// File: tb/thermo_alarm_reg_bench.sv
module thermo_alarm_reg_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       conv_valid = 1'b0;
   logic [8:0] conv_result = '0;
   logic [7:0] lim_high = '0;
   logic [7:0] lim_low = '0;
   logic [15:0] temp_reg;
   logic        alarm;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference model state
   integer      m_half = 170;
   logic        m_alarm = 1'b0;

   always #5 clk = ~clk;

   thermo_alarm_reg u_thermo_alarm_reg (
      .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_result(conv_result),
      .lim_high(lim_high), .lim_low(lim_low), .temp_reg(temp_reg), .alarm(alarm)
   );

   task automatic check_word(string req, logic [15:0] exp);
      checks++;
      if (temp_reg !== exp) begin
         failures++;
         $display("FAIL %s temp_reg actual=%h expected=%h", req, temp_reg, exp);
      end
   endtask

   task automatic check_flag(string req, logic exp);
      checks++;
      if (alarm !== exp) begin
         failures++;
         $display("FAIL %s alarm actual=%b expected=%b", req, alarm, exp);
      end
   endtask

   // Drive one cycle at the falling edge, advance the model, compare at the next falling edge
   task automatic step(logic v, logic [8:0] r, logic [7:0] h, logic [7:0] l,
                       string req_word, string req_flag);
      integer whole;
      integer hi;
      integer lo;
      conv_valid  = v;
      conv_result = r;
      lim_high    = h;
      lim_low     = l;
      if (v) begin
         m_half  = $signed(r);
         whole   = m_half >>> 1;
         hi      = $signed(h);
         lo      = $signed(l);
         m_alarm = (whole > hi) || (whole < lo);
      end
      @(negedge clk);
      check_word(req_word, m_half[15:0]);
      check_flag(req_flag, m_alarm);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check_word("R1", 16'h00AA);
      check_flag("R1", 1'b0);
      rst_n = 1'b1;
      step(1'b0, 9'h000, 8'd20, 8'd10, "R1", "R1");

      // R2: sign extension examples, limits wide open
      step(1'b1, 9'h032, 8'h7F, 8'h80, "R2", "R6");
      step(1'b1, 9'h001, 8'h7F, 8'h80, "R2", "R6");
      step(1'b1, 9'h1FF, 8'h7F, 8'h80, "R2", "R6");
      step(1'b1, 9'h1CE, 8'h7F, 8'h80, "R2", "R6");
      step(1'b1, 9'h192, 8'h7F, 8'h80, "R2", "R6");
      step(1'b1, 9'h000, 8'h7F, 8'h80, "R2", "R6");

      // R4 and R6: around the high limit (25 deg)
      step(1'b1, 9'h032, 8'd25, 8'd0, "R2", "R6");
      step(1'b1, 9'h034, 8'd25, 8'd0, "R2", "R4");
      step(1'b1, 9'h030, 8'd25, 8'd0, "R2", "R6");
      // R8: +25.5 is still 25 whole degrees
      step(1'b1, 9'h033, 8'd25, 8'd0, "R2", "R8");

      // R5: around the low limit (-25 deg)
      step(1'b1, 9'h1CE, 8'd10, 8'hE7, "R2", "R6");
      step(1'b1, 9'h1CC, 8'd10, 8'hE7, "R2", "R5");
      // R8: -25.5 floors to -26, below -25
      step(1'b1, 9'h1CD, 8'd10, 8'hE7, "R2", "R8");
      step(1'b1, 9'h1CF, 8'd10, 8'hE7, "R2", "R8");

      // R9: signed limits, negative high limit under a positive value
      step(1'b1, 9'h002, 8'hE7, 8'h80, "R2", "R9");
      step(1'b1, 9'h1F0, 8'h05, 8'hFE, "R2", "R9");

      // R7 and R3: alarm set, then limits widened without a strobe
      step(1'b1, 9'h0AA, 8'd50, 8'd0, "R2", "R4");
      step(1'b0, 9'h000, 8'h7F, 8'h80, "R3", "R7");
      step(1'b0, 9'h155, 8'h7F, 8'h80, "R3", "R7");
      step(1'b1, 9'h0AA, 8'h7F, 8'h80, "R2", "R6");
      step(1'b0, 9'h0AA, 8'd0, 8'd0, "R3", "R7");

      // R1: reset in mid-run
      rst_n = 1'b0;
      m_half = 170;
      m_alarm = 1'b0;
      @(negedge clk);
      check_word("R1", 16'h00AA);
      check_flag("R1", 1'b0);
      rst_n = 1'b1;
      step(1'b0, 9'h000, 8'd0, 8'd0, "R1", "R1");

      // random phase, limits may be inverted, strobes sparse
      for (int i = 0; i < 3000; i++) begin
         logic v;
         v = ($urandom_range(0, 2) == 0);
         step(v, 9'($urandom), 8'($urandom), 8'($urandom),
              v ? "R2" : "R3", v ? "R4" : "R7");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule